// File: doc/BRIEF.md
# Floating-Point Status Word Update Unit

This block owns the 32-bit status word of a floating-point unit. After an arithmetic operation finishes, the datapath hands over five exception flags. The unit ORs them into sticky flag bits at the top of the word and raises a one-cycle assist trap if any reported flag matches a set enable bit. After a comparison finishes, the datapath hands over a relation code, a five-bit condition mask, a target index and the compare's own exception flags. The unit first merges the flags and then records the selected condition bit. A nonzero index writes one bit of an indexed compare array. Index zero pushes the result into a primary condition bit, and the old primary bit enters a ten-deep compare queue.

The unit also decodes two controls from the word for the arithmetic pipeline: the rounding mode and a flag that flushes denormal inputs and results to zero. Software can replace the whole word through a write port. Operation results and compare results enter on valid/ready channels. A transfer takes effect only in a cycle where both valid and ready are high. The ready signals give a fixed priority: a software write blocks both channels, and a pending operation result blocks the compare channel. A producer must hold its valid signal and payload until it sees ready. Control and status pins are plain signals.

Top module: `fpsr_unit`

## Requirements
- R1: After reset the status word is zero, the rounding output is 0 (nearest-even), flush is low and the trap is low.
- R2: A software write replaces all 32 bits of the word, and the word is visible on the next cycle. In that cycle the trap is low.
- R3: The rounding output equals status bits 10:9: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R4: The flush output equals status bit 5, and it governs both denormal inputs and denormal results.
- R5: An accepted operation ORs op_flags[i] into status bit 27+i (i = 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) and leaves all other bits unchanged.
- R6: In the cycle after an accepted operation or compare, the trap output is high exactly when flags[i] and status bit i were both 1 for some i in 0..4, where status bits 4:0 are the enables in the same order as the flags. Otherwise the trap is low.
- R7: An accepted operation with all flags zero leaves the word unchanged and raises no trap.
- R8: The recorded compare bit is cmp_mask[4] for relation 0 (greater), mask[3] for 1 (less), mask[2] for 2 (equal) and mask[1] for 3 (unordered). Mask bit 0 has no effect on the recorded bit.
- R9: A compare with index y in 1..11 writes only status bit 22-y. With y in 12..15 the word changes only by its flags.
- R10: A compare with index 0 moves bits 21:12 into bits 20:11, moves the old bit 26 into bit 21 and writes the new result into bit 26.
- R11: The compare's flags are merged as in R5 before the compare bit is recorded, and both take effect in the same update.
- R12: op_ready is the inverse of sw_wr_en. cmp_ready is high only when neither sw_wr_en nor op_valid is high. A transfer that is offered without ready has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Replacement status word |
| op_valid | input | 1 | Operation result offered |
| op_ready | output | 1 | Operation result accepted this cycle |
| op_flags | input | 5 | Operation exception flags (bit 0 inexact ... bit 4 invalid) |
| cmp_valid | input | 1 | Compare result offered |
| cmp_ready | output | 1 | Compare result accepted this cycle |
| cmp_rel | input | 2 | Relation: 0 greater, 1 less, 2 equal, 3 unordered |
| cmp_mask | input | 5 | Condition mask; bit 0 marks a signaling compare |
| cmp_idx | input | 4 | Target index; 0 selects the queue |
| cmp_flags | input | 5 | Compare exception flags, same order as op_flags |
| status | output | 32 | Current status word |
| rnd_mode | output | 2 | Decoded rounding mode |
| flush_en | output | 1 | Denormal flush enable |
| assist_trap | output | 1 | One-cycle assist trap pulse |

## Verification
The flag path is swept over every pair of the 32 flag patterns and the 32 enable patterns. This separates the sticky OR from an overwrite and the per-bit enable match from a plain "any flag" trap. Compares run every relation against every mask, both queued and targeted. This shows which mask bit is chosen and that mask bit 0 is ignored. All sixteen indices are written with a 1 into a cleared word and with a 0 into a set word. This exposes wrong bit positions and out-of-range writes. Offers made at the same time check that lower-priority transfers are held off, and a compare that carries flags checks the order of the merge and the record.

// File: rtl/fpsr_pkg.sv
`timescale 1ns/1ps
// Shared layout constants and types for the status word unit.
package fpsr_pkg;
  localparam int WORD_W     = 32;
  localparam int FLAG_N     = 5;
  localparam int FLAG_LSB   = 27;  // sticky flags occupy 31:27
  localparam int ENA_LSB    = 0;   // trap enables occupy 4:0
  localparam int RND_LSB    = 9;   // rounding field 10:9
  localparam int FLUSH_BIT  = 5;
  localparam int PRIME_BIT  = 26;  // primary condition bit
  localparam int CQ_LEN     = 10;  // queue depth
  localparam int CQ_TOP     = 21;  // top of compare array / queue
  localparam int ARR_N      = CQ_LEN + 1;      // indexed array size
  localparam int ARR_LSB    = CQ_TOP - CQ_LEN; // bit 11
  localparam int IDX_W      = 4;
  localparam int MASK_W     = 5;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_POS  = 2'd2,
    RND_NEG  = 2'd3
  } rnd_e;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;
endpackage

// File: rtl/fpsr_exc_merge.sv
`timescale 1ns/1ps
// Sticky flag merge and enable match; purely combinational.
module fpsr_exc_merge
  import fpsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [FLAG_N-1:0] flags_i,
  output logic [WORD_W-1:0] word_o,
  output logic              trap_o
);
  logic [FLAG_N-1:0] hit;

  always_comb begin
    word_o = word_i;
    for (int i = 0; i < FLAG_N; i++) begin
      word_o[FLAG_LSB+i] = word_i[FLAG_LSB+i] | flags_i[i];
      hit[i]             = flags_i[i] & word_i[ENA_LSB+i];
    end
    trap_o = |hit;
  end
endmodule

// File: rtl/fpsr_cmp_record.sv
`timescale 1ns/1ps
// Records one compare outcome into the array or the queue.
module fpsr_cmp_record
  import fpsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  rel_e              rel_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  logic res;
  logic [WORD_W-1:0] shifted;

  // Relation picks one mask bit; bit 0 (signaling) is not a condition.
  always_comb begin
    unique case (rel_i)
      REL_GT:  res = mask_i[4];
      REL_LT:  res = mask_i[3];
      REL_EQ:  res = mask_i[2];
      default: res = mask_i[1];
    endcase
  end

  // Queue shift built per bit position.
  genvar k;
  generate
    for (k = 0; k < WORD_W; k++) begin : g_shift
      if (k >= ARR_LSB && k < CQ_TOP) begin : g_q
        assign shifted[k] = word_i[k+1];
      end else if (k == CQ_TOP) begin : g_head
        assign shifted[k] = word_i[PRIME_BIT];
      end else if (k == PRIME_BIT) begin : g_prime
        assign shifted[k] = res;
      end else begin : g_keep
        assign shifted[k] = word_i[k];
      end
    end
  endgenerate

  always_comb begin
    word_o = word_i;
    if (idx_i == '0) begin
      word_o = shifted;
    end else if (int'(idx_i) <= ARR_N) begin
      word_o[CQ_TOP + 1 - int'(idx_i)] = res;
    end
  end
endmodule

// File: rtl/fpsr_mode_decode.sv
`timescale 1ns/1ps
// Control field decode feeding the arithmetic pipeline.
module fpsr_mode_decode
  import fpsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output rnd_e              rnd_o,
  output logic              flush_o
);
  always_comb begin
    unique case (word_i[RND_LSB +: 2])
      2'd1:    rnd_o = RND_ZERO;
      2'd2:    rnd_o = RND_POS;
      2'd3:    rnd_o = RND_NEG;
      default: rnd_o = RND_NEAR;
    endcase
    flush_o = word_i[FLUSH_BIT];
  end
endmodule

// File: rtl/fpsr_unit.sv
`timescale 1ns/1ps
// Status word register with priority-ordered update sources.
module fpsr_unit
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_en,
  input  logic [31:0]       sw_wr_data,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [4:0]        op_flags,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [1:0]        cmp_rel,
  input  logic [4:0]        cmp_mask,
  input  logic [3:0]        cmp_idx,
  input  logic [4:0]        cmp_flags,
  output logic [31:0]       status,
  output logic [1:0]        rnd_mode,
  output logic              flush_en,
  output logic              assist_trap
);
  logic [WORD_W-1:0] word_q;
  logic              trap_q;
  logic [WORD_W-1:0] op_word, cmp_merged, cmp_word;
  logic              op_trap, cmp_trap;
  logic              op_fire, cmp_fire;
  rnd_e              rnd;

  // Fixed priority: software write, then operation, then compare.
  assign op_ready  = ~sw_wr_en;
  assign cmp_ready = ~sw_wr_en & ~op_valid;
  assign op_fire   = op_valid & op_ready;
  assign cmp_fire  = cmp_valid & cmp_ready;

  fpsr_exc_merge u_op_merge (
    .word_i (word_q),
    .flags_i(op_flags),
    .word_o (op_word),
    .trap_o (op_trap)
  );

  // Compare flags go in first, the condition bit is recorded on top.
  fpsr_exc_merge u_cmp_merge (
    .word_i (word_q),
    .flags_i(cmp_flags),
    .word_o (cmp_merged),
    .trap_o (cmp_trap)
  );

  fpsr_cmp_record u_rec (
    .word_i(cmp_merged),
    .rel_i (rel_e'(cmp_rel)),
    .mask_i(cmp_mask),
    .idx_i (cmp_idx),
    .word_o(cmp_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      trap_q <= 1'b0;
    end else if (sw_wr_en) begin
      word_q <= sw_wr_data;
      trap_q <= 1'b0;
    end else if (op_fire) begin
      word_q <= op_word;
      trap_q <= op_trap;
    end else if (cmp_fire) begin
      word_q <= cmp_word;
      trap_q <= cmp_trap;
    end else begin
      trap_q <= 1'b0;
    end
  end

  fpsr_mode_decode u_dec (
    .word_i (word_q),
    .rnd_o  (rnd),
    .flush_o(flush_en)
  );

  assign rnd_mode    = rnd;
  assign status      = word_q;
  assign assist_trap = trap_q;
endmodule

// File: rtl/fpsr_unit_chk.sv
`timescale 1ns/1ps
// Property checker attached to the status word unit.
module fpsr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_wr_en,
  input logic [31:0] sw_wr_data,
  input logic        op_valid,
  input logic        op_ready,
  input logic [4:0]  op_flags,
  input logic        cmp_valid,
  input logic        cmp_ready,
  input logic [3:0]  cmp_idx,
  input logic [4:0]  cmp_flags,
  input logic [31:0] status,
  input logic        assist_trap
);
  // R2
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (status == $past(sw_wr_data)) && !assist_trap);

  // R5
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> ((status[31:27] & $past(op_flags)) == $past(op_flags)));

  // R7
  quiet_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_flags == 5'd0) |=> ($stable(status) && !assist_trap));

  // R6
  trap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(assist_trap) |-> $past((op_valid && op_ready) || (cmp_valid && cmp_ready)));

  // R10
  queue_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready && cmp_idx == 4'd0) |=> (status[21] == $past(status[26])));

  // R9
  target_keeps_prime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready && cmp_idx != 4'd0) |=> (status[26] == $past(status[26])));

  // R12
  priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid || sw_wr_en) |-> !cmp_ready);

  // R11
  cmp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready) |=> ((status[31:27] & $past(cmp_flags)) == $past(cmp_flags)));
endmodule

bind fpsr_unit fpsr_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_wr_en   (sw_wr_en),
  .sw_wr_data (sw_wr_data),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .op_flags   (op_flags),
  .cmp_valid  (cmp_valid),
  .cmp_ready  (cmp_ready),
  .cmp_idx    (cmp_idx),
  .cmp_flags  (cmp_flags),
  .status     (status),
  .assist_trap(assist_trap)
);

// File: tb/tb_fpsr_unit.sv
`timescale 1ns/1ps
module tb_fpsr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [4:0]  op_flags = '0;
  logic        cmp_valid = 1'b0;
  logic        cmp_ready;
  logic [1:0]  cmp_rel = '0;
  logic [4:0]  cmp_mask = '0;
  logic [3:0]  cmp_idx = '0;
  logic [4:0]  cmp_flags = '0;
  logic [31:0] status;
  logic [1:0]  rnd_mode;
  logic        flush_en;
  logic        assist_trap;

  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_word = '0;
  logic        exp_trap = 1'b0;

  always #2.5 clk = ~clk;

  fpsr_unit dut (.*);

  // Reference arithmetic taken from the requirements.
  function automatic logic [31:0] m_flag(input logic [31:0] w, input logic [4:0] f);
    return w | ({27'd0, f} << 27);
  endfunction

  function automatic logic m_trap(input logic [31:0] w, input logic [4:0] f);
    return (f & w[4:0]) != 5'd0;
  endfunction

  function automatic logic [31:0] m_cmp(input logic [31:0] w, input int rel,
                                        input logic [4:0] mask, input int idx);
    logic c;
    logic old26;
    logic [31:0] q;
    c = (mask >> (4 - rel)) & 5'd1;
    if (idx == 0) begin
      old26 = w[26];
      q = (w >> 12) & 32'h3ff;
      w = (w & ~(32'h3ff << 11)) | (q << 11);
      w[21] = old26;
      w[26] = c;
    end else if (idx <= 11) begin
      w[22 - idx] = c;
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
    sw_wr_en = 1'b0;
    op_valid = 1'b0;
    cmp_valid = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] d);
    sw_wr_en = 1'b1; sw_wr_data = d;
    exp_word = d; exp_trap = 1'b0;
    settle();
  endtask

  task automatic do_op(input logic [4:0] f);
    op_valid = 1'b1; op_flags = f;
    exp_trap = m_trap(exp_word, f);
    exp_word = m_flag(exp_word, f);
    settle();
  endtask

  task automatic do_cmp(input int rel, input logic [4:0] mask, input int idx,
                        input logic [4:0] f);
    cmp_valid = 1'b1; cmp_rel = rel[1:0]; cmp_mask = mask;
    cmp_idx = idx[3:0]; cmp_flags = f;
    exp_trap = m_trap(exp_word, f);
    exp_word = m_cmp(m_flag(exp_word, f), rel, mask, idx);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 status", status, 32'd0);
    chk("R1 rnd", {30'd0, rnd_mode}, 32'd0);
    chk("R1 flush/trap", {30'd0, flush_en, assist_trap}, 32'd0);

    // R2 R3 R4: write every control combination
    for (int m = 0; m < 4; m++) begin
      for (int fl = 0; fl < 2; fl++) begin
        logic [31:0] d;
        d = 32'h5a5a_0000 | (m << 9) | (fl << 5) | 32'h0000_8003;
        do_write(d);
        chk("R2 write", status, d);
        chk("R2 trap", {31'd0, assist_trap}, 32'd0);
        chk("R3 rnd", {30'd0, rnd_mode}, m);
        chk("R4 flush", {31'd0, flush_en}, fl);
      end
    end

    // R5 R6 R7: every flag pattern against every enable pattern
    for (int en = 0; en < 32; en++) begin
      for (int f = 0; f < 32; f++) begin
        do_write(32'h0012_3440 | en);
        do_op(f[4:0]);
        chk(f == 0 ? "R7 word" : "R5 word", status, exp_word);
        chk(f == 0 ? "R7 trap" : "R6 trap", {31'd0, assist_trap}, {31'd0, exp_trap});
      end
    end
    // R6 trap lasts one cycle
    do_write(32'h0000_001f);
    do_op(5'h10);
    chk("R6 pulse", {31'd0, assist_trap}, 32'd1);
    @(negedge clk);
    chk("R6 pulse end", {31'd0, assist_trap}, 32'd0);

    // R8 R10: every relation and mask, queued
    do_write(32'h0ab5_5000);
    for (int r = 0; r < 4; r++) begin
      for (int mk = 0; mk < 32; mk++) begin
        do_cmp(r, mk[4:0], 0, 5'd0);
        chk("R8/R10 queued", status, exp_word);
      end
    end
    // R8 R9: every relation and mask, targeted at rotating index
    for (int r = 0; r < 4; r++) begin
      for (int mk = 0; mk < 32; mk++) begin
        do_cmp(r, mk[4:0], 1 + ((r * 32 + mk) % 15), 5'd0);
        chk("R8/R9 targeted", status, exp_word);
      end
    end
    // R9 R10: every index writing a 1 into zeros, then a 0 into ones
    for (int ix = 0; ix < 16; ix++) begin
      do_write(32'h0000_0000);
      do_cmp(0, 5'h10, ix, 5'd0);
      chk("R9/R10 set", status, exp_word);
      do_write(32'h07ff_fe00);
      do_cmp(2, 5'h1b, ix, 5'd0);
      chk("R9/R10 clear", status, exp_word);
    end

    // R11: compare carrying flags, with and without enable
    do_write(32'h0000_0004);
    do_cmp(3, 5'h02, 0, 5'h04);
    chk("R11 word", status, exp_word);
    chk("R11 trap", {31'd0, assist_trap}, 32'd1);
    do_cmp(1, 5'h08, 5, 5'h11);
    chk("R11 word2", status, exp_word);
    chk("R11 trap2", {31'd0, assist_trap}, 32'd0);

    // R12: back-pressure priority
    do_write(32'h0000_0000);
    op_valid = 1'b1; op_flags = 5'h01;
    cmp_valid = 1'b1; cmp_rel = 2'd0; cmp_mask = 5'h10; cmp_idx = 4'd0; cmp_flags = 5'h1f;
    #1;
    chk("R12 op_ready", {31'd0, op_ready}, 32'd1);
    chk("R12 cmp_ready", {31'd0, cmp_ready}, 32'd0);
    exp_word = m_flag(exp_word, 5'h01);
    settle();
    chk("R12 cmp held off", status, exp_word);
    sw_wr_en = 1'b1; sw_wr_data = 32'h0000_0600; op_valid = 1'b1; op_flags = 5'h1f;
    #1;
    chk("R12 op blocked", {30'd0, op_ready, cmp_ready}, 32'd0);
    settle();
    chk("R12 write wins", status, 32'h0000_0600);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule